// File: doc/BRIEF.md
# Serial Port Transmit Pin Controller

This block sits between the transmit side of a synchronous serial port and its pins. It produces the outgoing bit clock from two strobes, one for the rising phase and one for the falling phase, that arrive at the system clock rate. When the port drives both its clock and its frame sync, the block can gate that clock so that it runs only around each frame. The gated window opens while the frame sync is high and stays open for a fixed number of further bit clocks after the frame sync drops.

The block also drives the pin output enables. The data-pin enable is active-low. It follows the active-frame indication in normal mode and stays asserted at all times in pair-to-pair mode. In digital loopback, every output enable is released and the receive side takes the internal transmit clock, frame sync and data in place of the pins. The block also captures the transmit frame sync on either the launching edge or the opposite edge of the bit clock. The configuration is copied into a holding register only while the port is idle, so a frame in progress always completes under one setting.

Top module: `sp_txpin_ctrl`

## Requirements
- R1: Clock gating takes effect only when `cfg_gate_en`, `cfg_clkx_master` and `cfg_fsx_master` are all 1 in the held configuration. In every other case, every rising strobe is passed and the pin clock runs freely.
- R2: With gating in effect, a rising strobe is passed to `clkx_pin` only if `fsx_int` is 1 at that strobe, or if fewer than POST_CLKS rising strobes have gone by since the last strobe that saw `fsx_int` high.
- R3: With gating in effect and POST_CLKS=3, a frame sync that is high for N bit clocks produces exactly N+3 rising edges on `clkx_pin`. This equals FWID+4 when N = FWID+1.
- R4: While gating is in effect, `rx_clk` equals the transmit pin clock and `rx_fs` equals `fsx_int`, whatever `cfg_rxclk_int` and `cfg_rxfs_int` hold. Otherwise `rx_clk` is the transmit clock when `cfg_rxclk_int`=1 and `pin_clkr` when it is 0. Likewise, `rx_fs` is `fsx_int` when `cfg_rxfs_int`=1 and `pin_fsr` when it is 0.
- R5: In normal mode (`cfg_pair`=0, no loopback), `dx_oe_n` is 0 exactly while `frame_act` is 1, and 1 otherwise.
- R6: In pair-to-pair mode (`cfg_pair`=1, no loopback), `dx_oe_n` is 0 in every cycle, whatever `frame_act` holds.
- R7: In loopback (`cfg_loopback`=1), `clkx_oe`=0, `fsx_oe`=0 and `dx_oe_n`=1, and this takes priority over pair-to-pair mode. In the same mode, `rx_clk`, `rx_fs` and `rx_data` carry the transmit clock, `fsx_int` and `dx_int`. Outside loopback, `clkx_oe` equals `cfg_clkx_master`, `fsx_oe` equals `cfg_fsx_master` and `rx_data` equals `pin_dr`.
- R8: With `cfg_full_cycle`=0, `fs_smp` loads `fsx_int` on each falling strobe (the edge opposite to data launch). With `cfg_full_cycle`=1, it loads on each rising strobe (the launch edge). Between loads it holds its value.
- R9: A synchronous active-high `rst` clears the held configuration, the post-frame count, `clkx_pin` and `fs_smp` to 0.
- R10: The held configuration takes the `cfg_*` inputs only in a cycle where `fsx_int`=0, `frame_act`=0 and the post-frame count is zero. A change made during a frame therefore takes effect only after the window closes.
- R11: `clkx_pin` goes to 0 one cycle after every falling strobe, and goes to 1 one cycle after a passed rising strobe. While gated it stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_rise | input | 1 | Rising-phase strobe of the bit clock |
| bclk_fall | input | 1 | Falling-phase strobe of the bit clock |
| fsx_int | input | 1 | Internal transmit frame sync |
| dx_int | input | 1 | Internal transmit data |
| frame_act | input | 1 | A frame is being transmitted |
| cfg_gate_en | input | 1 | Request clock gating |
| cfg_pair | input | 1 | Pair-to-pair connection |
| cfg_loopback | input | 1 | Digital loopback |
| cfg_full_cycle | input | 1 | Sample frame sync on the launch edge |
| cfg_clkx_master | input | 1 | Transmit clock is an output |
| cfg_fsx_master | input | 1 | Transmit frame sync is an output |
| cfg_rxclk_int | input | 1 | Receive clock taken from the transmit clock |
| cfg_rxfs_int | input | 1 | Receive frame sync taken from `fsx_int` |
| pin_clkr | input | 1 | Receive clock pin |
| pin_fsr | input | 1 | Receive frame sync pin |
| pin_dr | input | 1 | Receive data pin |
| clkx_pin | output | 1 | Transmit clock to pin |
| clkx_oe | output | 1 | Transmit clock pin enable, active high |
| fsx_pin | output | 1 | Transmit frame sync to pin |
| fsx_oe | output | 1 | Transmit frame sync pin enable, active high |
| dx_pin | output | 1 | Transmit data to pin |
| dx_oe_n | output | 1 | Data pin enable, active low |
| rx_clk | output | 1 | Selected receive clock |
| rx_fs | output | 1 | Selected receive frame sync |
| rx_data | output | 1 | Selected receive data |
| fs_smp | output | 1 | Sampled transmit frame sync |

## Verification
The bench builds the block with the default POST_CLKS=3. With that value, the post-frame tail is short enough that a bench model can count each passed edge, and the FWID+4 edge count for frame widths of one and three bit clocks can be checked directly. The bit clock runs at one quarter of the system rate. This spacing leaves room to change the configuration in the middle of a frame, to confirm that the change waits until the tail has drained, and to watch the free-running clock return afterwards.

// File: rtl/sp_txpin_pkg.sv
package sp_txpin_pkg;

    typedef struct packed {
        logic gate_en;
        logic pair;
        logic loopback;
        logic full_cycle;
        logic clkx_master;
        logic fsx_master;
        logic rxclk_int;
        logic rxfs_int;
    } txpin_cfg_t;

    localparam txpin_cfg_t CFG_RESET = '0;

    function automatic logic gating_on(input txpin_cfg_t c);
        return c.gate_en & c.clkx_master & c.fsx_master;
    endfunction

endpackage

// File: rtl/sp_txpin_cfg_hold.sv
module sp_txpin_cfg_hold
    import sp_txpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  txpin_cfg_t cfg_in,
    output txpin_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (!busy)
            cfg_q <= cfg_in;
    end

    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));
endmodule

// File: rtl/sp_txpin_gate.sv
module sp_txpin_gate #(
    parameter int POST_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic fs,
    input  logic gate_on,
    output logic clk_q,
    output logic tail_busy
);
    localparam int CNT_W = $clog2(POST_CLKS + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(POST_CLKS);

    logic [CNT_W-1:0] tail_cnt;
    logic             window;

    assign window    = !gate_on || fs || (tail_cnt != '0);
    assign tail_busy = (tail_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_cnt <= '0;
        end else if (bclk_rise) begin
            if (fs)
                tail_cnt <= RELOAD;
            else if (tail_cnt != '0)
                tail_cnt <= tail_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            clk_q <= 1'b0;
        else if (bclk_fall)
            clk_q <= 1'b0;
        else if (bclk_rise && window)
            clk_q <= 1'b1;
    end

    assert_fall_low_R11: assert property (@(posedge clk) disable iff (rst)
        bclk_fall |=> !clk_q);
    assert_closed_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (gate_on && bclk_rise && !bclk_fall && !fs && tail_cnt == '0) |=> $stable(clk_q));
    assert_free_run_R1: assert property (@(posedge clk) disable iff (rst)
        (!gate_on && bclk_rise && !bclk_fall) |=> clk_q);
endmodule

// File: rtl/sp_txpin_fs_sample.sv
module sp_txpin_fs_sample (
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic full_cycle,
    input  logic fs,
    output logic fs_q
);
    logic load;

    assign load = full_cycle ? bclk_rise : bclk_fall;

    always_ff @(posedge clk) begin
        if (rst)
            fs_q <= 1'b0;
        else if (load)
            fs_q <= fs;
    end

    assert_full_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (full_cycle && bclk_rise) |=> fs_q == $past(fs));
    assert_half_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (!full_cycle && bclk_fall) |=> fs_q == $past(fs));
endmodule

// File: rtl/sp_txpin_ctrl.sv
module sp_txpin_ctrl
    import sp_txpin_pkg::*;
#(
    parameter int POST_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic fsx_int,
    input  logic dx_int,
    input  logic frame_act,
    input  logic cfg_gate_en,
    input  logic cfg_pair,
    input  logic cfg_loopback,
    input  logic cfg_full_cycle,
    input  logic cfg_clkx_master,
    input  logic cfg_fsx_master,
    input  logic cfg_rxclk_int,
    input  logic cfg_rxfs_int,
    input  logic pin_clkr,
    input  logic pin_fsr,
    input  logic pin_dr,
    output logic clkx_pin,
    output logic clkx_oe,
    output logic fsx_pin,
    output logic fsx_oe,
    output logic dx_pin,
    output logic dx_oe_n,
    output logic rx_clk,
    output logic rx_fs,
    output logic rx_data,
    output logic fs_smp
);
    txpin_cfg_t cfg_in, cfg;
    logic       tail_busy, tx_clk, gate_on, busy;

    assign cfg_in = '{gate_en: cfg_gate_en, pair: cfg_pair, loopback: cfg_loopback,
                      full_cycle: cfg_full_cycle, clkx_master: cfg_clkx_master,
                      fsx_master: cfg_fsx_master, rxclk_int: cfg_rxclk_int,
                      rxfs_int: cfg_rxfs_int};
    assign busy    = fsx_int || frame_act || tail_busy;
    assign gate_on = gating_on(cfg);

    sp_txpin_cfg_hold u_hold (
        .clk(clk), .rst(rst), .busy(busy), .cfg_in(cfg_in), .cfg_q(cfg)
    );

    sp_txpin_gate #(.POST_CLKS(POST_CLKS)) u_gate (
        .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fs(fsx_int), .gate_on(gate_on), .clk_q(tx_clk), .tail_busy(tail_busy)
    );

    sp_txpin_fs_sample u_fs (
        .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .full_cycle(cfg.full_cycle), .fs(fsx_int), .fs_q(fs_smp)
    );

    assign clkx_pin = tx_clk;
    assign fsx_pin  = fsx_int;
    assign dx_pin   = dx_int;

    always_comb begin
        if (cfg.loopback) begin
            clkx_oe = 1'b0;
            fsx_oe  = 1'b0;
            dx_oe_n = 1'b1;
            rx_clk  = tx_clk;
            rx_fs   = fsx_int;
            rx_data = dx_int;
        end else begin
            clkx_oe = cfg.clkx_master;
            fsx_oe  = cfg.fsx_master;
            dx_oe_n = cfg.pair ? 1'b0 : !frame_act;
            rx_clk  = (gate_on || cfg.rxclk_int) ? tx_clk : pin_clkr;
            rx_fs   = (gate_on || cfg.rxfs_int) ? fsx_int : pin_fsr;
            rx_data = pin_dr;
        end
    end

    assert_loop_oe_R7: assert property (@(posedge clk) disable iff (rst)
        cfg.loopback |-> (!clkx_oe && !fsx_oe && dx_oe_n));
    assert_pair_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.pair && !cfg.loopback) |-> !dx_oe_n);
    assert_gate_rx_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_on && !cfg.loopback) |-> (rx_clk == clkx_pin && rx_fs == fsx_pin));
endmodule

// File: tb/sim_sp_txpin_ctrl.sv
module sim_sp_txpin_ctrl;
    logic clk = 0, rst = 1;
    logic bclk_rise = 0, bclk_fall = 0, fsx_int = 0, dx_int = 0, frame_act = 0;
    logic cfg_gate_en = 0, cfg_pair = 0, cfg_loopback = 0, cfg_full_cycle = 0;
    logic cfg_clkx_master = 0, cfg_fsx_master = 0, cfg_rxclk_int = 0, cfg_rxfs_int = 0;
    logic pin_clkr = 0, pin_fsr = 0, pin_dr = 0;
    logic clkx_pin, clkx_oe, fsx_pin, fsx_oe, dx_pin, dx_oe_n, rx_clk, rx_fs, rx_data, fs_smp;

    int total = 0, bad = 0, cycles = 0, edges = 0;
    logic prev_clk = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural model state
    logic m_gate = 0, m_pair = 0, m_loop = 0, m_full = 0, m_cm = 0, m_fm = 0, m_rci = 0, m_rfi = 0;
    int   m_tail = 0;
    logic m_clk = 0, m_fs = 0;

    always #10 clk = ~clk;

    sp_txpin_ctrl u0 (.*);

    always @(posedge clk) begin
        logic busy, on, open;
        cycles++;
        if (rst) begin
            {m_gate, m_pair, m_loop, m_full, m_cm, m_fm, m_rci, m_rfi} = '0;
            m_tail = 0; m_clk = 0; m_fs = 0;
        end else begin
            busy = fsx_int || frame_act || (m_tail != 0);
            on   = m_gate && m_cm && m_fm;
            open = !on || fsx_int || (m_tail > 0);
            if (bclk_fall) m_clk = 0;
            else if (bclk_rise && open) m_clk = 1;
            if (m_full ? bclk_rise : bclk_fall) m_fs = fsx_int;
            if (bclk_rise) m_tail = fsx_int ? 3 : (m_tail > 0 ? m_tail - 1 : 0);
            if (!busy) begin
                m_gate = cfg_gate_en; m_pair = cfg_pair; m_loop = cfg_loopback;
                m_full = cfg_full_cycle; m_cm = cfg_clkx_master; m_fm = cfg_fsx_master;
                m_rci = cfg_rxclk_int; m_rfi = cfg_rxfs_int;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic on, e_oen, e_rxc, e_rxf, e_rxd;
        if (!rst) begin
            on    = m_gate && m_cm && m_fm;
            e_oen = m_loop ? 1'b1 : (m_pair ? 1'b0 : !frame_act);
            e_rxc = (m_loop || on || m_rci) ? m_clk : pin_clkr;
            e_rxf = (m_loop || on || m_rfi) ? fsx_int : pin_fsr;
            e_rxd = m_loop ? dx_int : pin_dr;
            chk("R11", "clkx_pin", clkx_pin, m_clk);
            chk("R7", "clkx_oe", clkx_oe, !m_loop && m_cm);
            chk("R7", "fsx_oe", fsx_oe, !m_loop && m_fm);
            chk("R7", "fsx_pin", fsx_pin, fsx_int);
            chk("R7", "dx_pin", dx_pin, dx_int);
            chk(m_loop ? "R7" : (m_pair ? "R6" : "R5"), "dx_oe_n", dx_oe_n, e_oen);
            chk("R4", "rx_clk", rx_clk, e_rxc);
            chk("R4", "rx_fs", rx_fs, e_rxf);
            chk("R7", "rx_data", rx_data, e_rxd);
            chk("R8", "fs_smp", fs_smp, m_fs);
            if (clkx_pin && !prev_clk) edges++;
            prev_clk = clkx_pin;
        end
    end

    task automatic bitclk(input logic fs, input logic act);
        for (int p = 0; p < 4; p++) begin
            @(posedge clk); #2;
            bclk_rise = (p == 0);
            bclk_fall = (p == 2);
            fsx_int   = fs;
            frame_act = act;
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dx_int    = lfsr[0];
            pin_dr    = lfsr[3];
            pin_clkr  = ~pin_clkr;
            pin_fsr   = (p == 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bitclk(1'b0, 1'b0);
    endtask

    task automatic frame(input int w);
        for (int i = 0; i < w; i++) bitclk(1'b1, 1'b1);
    endtask

    initial begin
        #4000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk); #1;
        // R9 reset state
        chk("R9", "clkx_pin after reset", clkx_pin, 1'b0);
        chk("R9", "fs_smp after reset", fs_smp, 1'b0);
        chk("R9", "clkx_oe after reset", clkx_oe, 1'b0);
        chk("R9", "dx_oe_n after reset", dx_oe_n, 1'b1);

        // free run, no masters: R1
        idle(2); frame(2); idle(2);
        edges = 0; idle(6);
        chk_int("R1", "free-run edges", edges, 6);

        // gating requested without clock master: still free run (R1)
        cfg_gate_en = 1; cfg_fsx_master = 1; idle(2);
        edges = 0; idle(8);
        chk_int("R1", "edges gate_en without clock master", edges, 8);

        // full gating: idle stays silent (R2), frame widths (R3)
        cfg_clkx_master = 1; idle(4);
        edges = 0; idle(5);
        chk_int("R2", "edges while gated idle", edges, 0);
        chk("R11", "pin low while gated", clkx_pin, 1'b0);
        edges = 0; frame(1); idle(6);
        chk_int("R3", "edges FWID=0", edges, 4);
        edges = 0; frame(3); idle(6);
        chk_int("R3", "edges FWID=2", edges, 6);
        // receive sources ignored during gating (R4)
        cfg_rxclk_int = 0; cfg_rxfs_int = 0; idle(1); frame(2); idle(4);

        // change during a frame is deferred (R10)
        edges = 0; frame(1);
        cfg_gate_en = 0; frame(2); idle(3);
        chk_int("R10", "edges before deferred change applies", edges, 6);
        edges = 0; idle(3);
        chk_int("R10", "edges after change applies", edges, 3);

        // receive from pins vs internal (R4)
        cfg_clkx_master = 0; cfg_fsx_master = 0; idle(2); frame(2); idle(2);
        cfg_rxclk_int = 1; cfg_rxfs_int = 1; idle(2); frame(2); idle(2);

        // pair-to-pair (R6)
        cfg_pair = 1; idle(2); frame(3); idle(2);
        chk("R6", "dx_oe_n idle pair", dx_oe_n, 1'b0);

        // loopback overrides pair (R7)
        cfg_loopback = 1; cfg_clkx_master = 1; cfg_fsx_master = 1; idle(2); frame(3); idle(2);
        chk("R7", "dx_oe_n loopback", dx_oe_n, 1'b1);
        chk("R7", "clkx_oe loopback", clkx_oe, 1'b0);
        cfg_loopback = 0; cfg_pair = 0; idle(2); frame(2); idle(2);

        // full-cycle sampling (R8)
        cfg_full_cycle = 1; idle(2); frame(1); idle(1); frame(2); idle(2);
        cfg_full_cycle = 0; idle(2); frame(1); idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule